// File: doc/BRIEF.md
# Gated Store Buffer with Commit and Rollback

This block holds speculative stores, each an address and data pair, produced while a translated code region runs. Held stores do not reach memory until the region commits. A commit pulse releases every store held at that moment to a memory write port. The stores leave in program order, one per accepted valid/ready transfer. A rollback pulse throws away every store that has not yet been committed, so memory returns to the state of the last commit point. Both pulses are meant to be raised in the same cycle as the matching register-file commit or rollback, which keeps register state and memory state consistent.

A load lookup port searches every store still in the buffer, committed or not. It returns the data of the youngest store to the same word address, so a load sees its own earlier stores before they reach memory. Three ring pointers split the buffer into three regions: committed stores still draining, speculative stores, and free slots. When all slots are used, the enqueue port is stalled.

Top module: `gated_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `mem_valid`, `st_stall` and `ld_hit` are 0.
- R2: A store accepted on the enqueue port never appears on the memory port until a later `cmt_pulse` covers it; without a commit, `mem_valid` stays 0.
- R3: From the cycle after a `cmt_pulse`, every covered store is presented on `mem_valid`/`mem_addr`/`mem_data` in enqueue order. One leaves at each rising edge where `mem_valid` and `mem_ready` are both 1. Address and data hold while `mem_ready` is 0.
- R4: A store accepted in the same cycle as a `cmt_pulse`, or later, is not covered by that commit and stays gated.
- R5: `rbk_pulse` discards all uncommitted stores and keeps committed stores that are still draining. If `cmt_pulse` and `rbk_pulse` arrive together, the rollback wins and the commit has no effect.
- R6: A store presented in the same cycle as `rbk_pulse` is dropped.
- R7: `st_stall` is 1 exactly when 8 stores (the default depth) are held, committed or not. A store presented while `st_stall` is 1 is not accepted.
- R8: `ld_hit`/`ld_data` respond combinationally to `ld_addr`. They give the data of the youngest held store whose full address equals `ld_addr`, and `ld_hit` is 0 when no held store matches.
- R9: When a drain frees a slot of a full buffer, `st_stall` returns to 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store enqueue request |
| st_addr | input | 32 | Store word address |
| st_data | input | 32 | Store data |
| st_stall | output | 1 | Buffer full; request not accepted |
| ld_addr | input | 32 | Load lookup word address |
| ld_hit | output | 1 | A held store matches `ld_addr` |
| ld_data | output | 32 | Data of the youngest matching store |
| cmt_pulse | input | 1 | Commit the current speculative stores |
| rbk_pulse | input | 1 | Discard the current speculative stores |
| mem_valid | output | 1 | A committed store is offered to memory |
| mem_addr | output | 32 | Address of the offered store |
| mem_data | output | 32 | Data of the offered store |
| mem_ready | input | 1 | Memory accepts the offered store this cycle |

## Verification
The load result is due in the same cycle as `ld_addr`. A store becomes visible to lookups only after the rising edge that accepts it. A commit shows on `mem_valid` after the edge that samples it, and a drain or rollback changes the memory port and `st_stall` after that same edge. The bench therefore drives every input at the falling edge and reads all outputs 1 ns later. At that point the reading reflects exactly the edges already taken. A queue model inside the bench is then advanced with the input values the design sampled at the next rising edge.

// File: rtl/gsb_pkg.sv
package gsb_pkg;

  // Which pointer event applies this cycle; rollback outranks commit.
  typedef enum logic [1:0] {
    GATE_NONE     = 2'd0,
    GATE_COMMIT   = 2'd1,
    GATE_ROLLBACK = 2'd2
  } gate_ev_e;

  // Number of steps from one ring pointer to another, modulo span.
  function automatic int unsigned ring_dist(int unsigned from_p,
                                            int unsigned to_p,
                                            int unsigned span);
    return (to_p + span - from_p) % span;
  endfunction

  // Advance a ring pointer by one.
  function automatic int unsigned ring_step(int unsigned p, int unsigned span);
    return (p + 1) % span;
  endfunction

  // Physical slot that lies off slots after base.
  function automatic int unsigned slot_of(int unsigned base, int unsigned off,
                                          int unsigned depth);
    return (base + off) % depth;
  endfunction

endpackage

// File: rtl/gsb_ptr_ctrl.sv
module gsb_ptr_ctrl
  import gsb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_req,
  input  logic          commit_i,
  input  logic          rollback_i,
  input  logic          mem_ready,
  output logic          enq_fire,
  output logic          drain_valid,
  output logic          full,
  output logic [CW-1:0] occ,
  output logic [IW-1:0] head_idx,
  output logic [IW-1:0] tail_idx
);
  localparam int PW = IW + 1;
  localparam int unsigned SPAN = 2 * DEPTH;

  // head: oldest held store; cmt: first speculative store; tail: next free slot
  logic [PW-1:0] head_q, cmt_q, tail_q;
  logic [PW-1:0] head_d, cmt_d, tail_d;
  gate_ev_e      gate_ev;
  logic          drain_fire;
  logic [CW-1:0] spec_cnt;

  always_comb begin
    if (rollback_i)    gate_ev = GATE_ROLLBACK;
    else if (commit_i) gate_ev = GATE_COMMIT;
    else               gate_ev = GATE_NONE;
  end

  assign occ         = CW'(ring_dist(32'(head_q), 32'(tail_q), SPAN));
  assign spec_cnt    = CW'(ring_dist(32'(cmt_q), 32'(tail_q), SPAN));
  assign full        = (occ == CW'(DEPTH));
  assign drain_valid = (head_q != cmt_q);
  assign drain_fire  = drain_valid & mem_ready;
  assign enq_fire    = enq_req & ~full & (gate_ev != GATE_ROLLBACK);
  assign head_idx    = head_q[IW-1:0];
  assign tail_idx    = tail_q[IW-1:0];

  always_comb begin
    head_d = drain_fire ? PW'(ring_step(32'(head_q), SPAN)) : head_q;
    cmt_d  = cmt_q;
    tail_d = tail_q;
    unique case (gate_ev)
      GATE_COMMIT:   cmt_d  = tail_q;   // store entering this cycle stays gated
      GATE_ROLLBACK: tail_d = cmt_q;    // drop the speculative region only
      default: ;
    endcase
    if (enq_fire) tail_d = PW'(ring_step(32'(tail_q), SPAN));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      cmt_q  <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      cmt_q  <= cmt_d;
      tail_q <= tail_d;
    end
  end

  // R7: occupancy never exceeds the depth
  a_r7_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  // R3: draining never runs past the commit boundary
  a_r3_head_within_commit: assert property (@(posedge clk) disable iff (!rst_n)
    ring_dist(32'(head_q), 32'(cmt_q), SPAN) <= ring_dist(32'(head_q), 32'(tail_q), SPAN));

  // R5: after a rollback no speculative store remains
  a_r5_rollback_empties_spec: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_ev == GATE_ROLLBACK) |=> (spec_cnt == '0));

  // R5: rollback leaves the commit boundary where it was
  a_r5_rollback_keeps_cmt: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_ev == GATE_ROLLBACK) |=> $stable(cmt_q));

  // R7: a full buffer accepts nothing
  a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (full && gate_ev != GATE_ROLLBACK) |=> $stable(tail_q));

endmodule

// File: rtl/gsb_entry_store.sv
module gsb_entry_store
  import gsb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] head_idx,
  input  logic [CW-1:0] live_cnt,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data
);
  logic [AW-1:0] slot_addr [DEPTH];
  logic [DW-1:0] slot_data [DEPTH];
  logic [DEPTH-1:0] age_match;   // bit i: the store i places after head matches

  always_ff @(posedge clk) begin
    if (wr_en) begin
      slot_addr[wr_idx] <= wr_addr;
      slot_data[wr_idx] <= wr_data;
    end
  end

  assign head_addr = slot_addr[head_idx];
  assign head_data = slot_data[head_idx];

  // Compare every live slot in age order.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    localparam int unsigned OFF = g;
    assign age_match[g] = (OFF < 32'(live_cnt)) &&
      (slot_addr[IW'(slot_of(32'(head_idx), OFF, DEPTH))] == lk_addr);
  end

  // Youngest match wins: a later age overrides an earlier one.
  always_comb begin
    lk_hit  = 1'b0;
    lk_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (age_match[i]) begin
        lk_hit  = 1'b1;
        lk_data = slot_data[IW'(slot_of(32'(head_idx), 32'(i), DEPTH))];
      end
    end
  end

endmodule

// File: rtl/gated_store_buffer.sv
module gated_store_buffer #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_stall,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  input  logic          cmt_pulse,
  input  logic          rbk_pulse,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ready
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          enq_fire;
  logic          drain_valid;
  logic          buf_full;
  logic [CW-1:0] occ;
  logic [IW-1:0] head_idx, tail_idx;

  gsb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .enq_req    (st_valid),
    .commit_i   (cmt_pulse),
    .rollback_i (rbk_pulse),
    .mem_ready  (mem_ready),
    .enq_fire   (enq_fire),
    .drain_valid(drain_valid),
    .full       (buf_full),
    .occ        (occ),
    .head_idx   (head_idx),
    .tail_idx   (tail_idx)
  );

  gsb_entry_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk      (clk),
    .wr_en    (enq_fire),
    .wr_idx   (tail_idx),
    .wr_addr  (st_addr),
    .wr_data  (st_data),
    .head_idx (head_idx),
    .live_cnt (occ),
    .head_addr(mem_addr),
    .head_data(mem_data),
    .lk_addr  (ld_addr),
    .lk_hit   (ld_hit),
    .lk_data  (ld_data)
  );

  assign st_stall  = buf_full;
  assign mem_valid = drain_valid;

  // R3: an offered store holds until memory takes it
  a_r3_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R2: nothing is released to memory without a commit
  a_r2_no_release_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_valid && !cmt_pulse) |=> !mem_valid);

  // R6: a store beside a rollback never enters
  a_r6_drop_store_on_rollback: assert property (@(posedge clk) disable iff (!rst_n)
    rbk_pulse |-> !enq_fire);

  // R1: empty right after reset
  a_r1_reset_empty: assert property (@(posedge clk)
    !rst_n |=> (!mem_valid && !st_stall));

endmodule

// File: tb/gated_store_buffer_bench.sv
module gated_store_buffer_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid, cmt_pulse, rbk_pulse, mem_ready;
  logic [31:0] st_addr, st_data, ld_addr;
  logic        st_stall, ld_hit, mem_valid;
  logic [31:0] ld_data, mem_addr, mem_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] cq_a[$], cq_d[$], sq_a[$], sq_d[$];

  always #5 clk = ~clk;

  gated_store_buffer #(.DEPTH(DEPTH), .AW(32), .DW(32)) u_gated_store_buffer (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_stall(st_stall),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
    .cmt_pulse(cmt_pulse), .rbk_pulse(rbk_pulse),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ready(mem_ready)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Youngest held store to addr a: speculative first, then committed.
  function automatic logic [32:0] model_look(input logic [31:0] a);
    for (int i = sq_a.size() - 1; i >= 0; i--)
      if (sq_a[i] == a) return {1'b1, sq_d[i]};
    for (int i = cq_a.size() - 1; i >= 0; i--)
      if (cq_a[i] == a) return {1'b1, cq_d[i]};
    return 33'd0;
  endfunction

  function automatic bit model_full();
    return (cq_a.size() + sq_a.size()) == DEPTH;
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input bit sv, input logic [31:0] sa, input logic [31:0] sd,
                      input bit cm, input bit rb, input bit rdy, input logic [31:0] la);
    logic [32:0] exp_ld;
    bit          was_full;
    st_valid = sv; st_addr = sa; st_data = sd;
    cmt_pulse = cm; rbk_pulse = rb; mem_ready = rdy; ld_addr = la;
    #1;
    chk("R3 mem_valid", {63'd0, mem_valid}, {63'd0, cq_a.size() > 0});
    if (cq_a.size() > 0) begin
      chk("R3 mem_addr order", {32'd0, mem_addr}, {32'd0, cq_a[0]});
      chk("R3 mem_data order", {32'd0, mem_data}, {32'd0, cq_d[0]});
    end
    chk("R7 st_stall", {63'd0, st_stall}, {63'd0, model_full()});
    exp_ld = model_look(la);
    chk("R8 ld_hit", {63'd0, ld_hit}, {63'd0, exp_ld[32]});
    if (exp_ld[32]) chk("R8 ld_data youngest", {32'd0, ld_data}, {32'd0, exp_ld[31:0]});
    was_full = model_full();
    @(posedge clk);
    if (cq_a.size() > 0 && rdy) begin
      void'(cq_a.pop_front());
      void'(cq_d.pop_front());
    end
    if (rb) begin
      sq_a.delete(); sq_d.delete();
    end else if (cm) begin
      foreach (sq_a[i]) begin cq_a.push_back(sq_a[i]); cq_d.push_back(sq_d[i]); end
      sq_a.delete(); sq_d.delete();
    end
    if (sv && !was_full && !rb) begin
      sq_a.push_back(sa); sq_d.push_back(sd);
    end
    @(negedge clk);
  endtask

  task automatic probe(input logic [31:0] la);
    st_valid = 1'b0; cmt_pulse = 1'b0; rbk_pulse = 1'b0; mem_ready = 1'b0; ld_addr = la;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0b1d));
    rst_n = 1'b0;
    st_valid = 0; st_addr = 0; st_data = 0; cmt_pulse = 0; rbk_pulse = 0;
    mem_ready = 0; ld_addr = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 mem_valid after reset", {63'd0, mem_valid}, 64'd0);
    chk("R1 st_stall after reset", {63'd0, st_stall}, 64'd0);
    chk("R1 ld_hit after reset", {63'd0, ld_hit}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: stores held without a commit never reach memory
    step(1, 32'h10, 32'hA1, 0, 0, 1, 32'h10);
    step(1, 32'h11, 32'hA2, 0, 0, 1, 32'h10);
    step(1, 32'h10, 32'hA3, 0, 0, 1, 32'h10);
    step(0, 0, 0, 0, 0, 1, 32'h10);
    probe(32'h10);
    chk("R2 gated without commit", {63'd0, mem_valid}, 64'd0);
    chk("R8 youngest of two", {32'd0, ld_data}, 64'hA3);

    // R4: store beside the commit stays gated after the rest drain
    step(1, 32'h12, 32'hB1, 1, 0, 0, 32'h12);
    repeat (4) step(0, 0, 0, 0, 0, 1, 32'h12);
    probe(32'h12);
    chk("R4 same-cycle store still gated", {63'd0, mem_valid}, 64'd0);
    chk("R4 gated store still held", {63'd0, ld_hit}, 64'd1);

    // R5: rollback discards it
    step(0, 0, 0, 0, 1, 0, 32'h12);
    probe(32'h12);
    chk("R5 rolled back store gone", {63'd0, ld_hit}, 64'd0);

    // R6: store alongside rollback is dropped
    step(1, 32'h13, 32'hC1, 0, 1, 0, 32'h13);
    probe(32'h13);
    chk("R6 store in rollback cycle dropped", {63'd0, ld_hit}, 64'd0);

    // R5: committed stores survive a later rollback; commit+rollback together
    step(1, 32'h20, 32'hD1, 0, 0, 0, 32'h20);
    step(1, 32'h21, 32'hD2, 1, 0, 0, 32'h20);
    step(1, 32'h22, 32'hD3, 0, 0, 0, 32'h21);
    step(0, 0, 0, 1, 1, 0, 32'h22);
    probe(32'h20);
    chk("R5 committed kept after rollback", {63'd0, mem_valid}, 64'd1);
    chk("R5 committed head address", {32'd0, mem_addr}, 64'h20);
    ld_addr = 32'h22; #1;
    chk("R5 rollback beats commit", {63'd0, ld_hit}, 64'd0);
    repeat (3) step(0, 0, 0, 0, 0, 1, 0);

    // R7 / R9: fill, stall, then free one slot
    for (int k = 0; k < DEPTH; k++) step(1, 32'h30 + k, 32'hE0 + k, 0, 0, 0, 32'h30);
    step(0, 0, 0, 1, 0, 0, 32'h37);
    probe(32'h38);
    chk("R7 stall at full", {63'd0, st_stall}, 64'd1);
    step(1, 32'h38, 32'hEE, 0, 0, 1, 32'h38);
    probe(32'h38);
    chk("R7 stalled store not taken", {63'd0, ld_hit}, 64'd0);
    chk("R9 stall released after drain", {63'd0, st_stall}, 64'd0);
    repeat (10) step(0, 0, 0, 0, 0, 1, 0);

    // Random mix against the model
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 100) < 60, $urandom % 8, $urandom,
           ($urandom % 100) < 8, ($urandom % 100) < 4,
           ($urandom % 100) < 70, $urandom % 8);
    end
    finish_run();
  end
endmodule